// File: doc/BRIEF.md
# Quadrature-Locking Drive Loop for an LC Resonator

This block excites an LC resonator with a square wave and holds that drive on the tank's resonant frequency. A phase accumulator advances by a frequency word on every clock, and its top bit is the drive pin. Two feedback signals come back from the analog side: a zero-crossing sense and a quadrature sense. Each is resynchronised into the clock domain. An exclusive-OR of the two acts as a bang-bang phase detector, and on every clock it moves the frequency word one count up or down. The loop comes to rest where the quadrature sense lags the zero sense by a quarter period.

Two limits keep the loop away from false locks. The word starts at a nominal value when reset is released, so the loop does not sweep up from zero through the subharmonics. A low-frequency flag forces upward steps whenever the word is below a floor. That floor lies 2^RANGE_W octaves under the nominal value. The word also saturates at both ends of its range, so a constant detector output cannot make it wrap around and sweep again. A build option captures the sense inputs on both clock edges. In that mode, two disagreeing half-cycle decisions cancel to a zero step.

Top module: `lc_quad_dpll`

## Requirements
- R1: While reset is high, freq_word equals FREQ_NOM and tank_drive is 0.
- R2: With single-edge capture, once the synchroniser has settled, the word falls by exactly 1 per clock while the synchronised sense_zero and sense_quad differ (XOR = 1), and rises by exactly 1 per clock while they are equal (XOR = 0).
- R3: With dual-edge capture, the word rises by 1 when both half-cycle XOR samples are 0, falls by 1 when both are 1, and holds when they disagree. Held constant inputs therefore give the same ±1 per clock as R2.
- R4: The floor is FREQ_NOM shifted right by 2^RANGE_W bit positions. Whenever the word is below the floor, the next step is +1 whatever the detector says. Under a detector held at 1, the word settles alternating between floor-1 and floor, and it never goes lower.
- R5: The low-frequency flag is consistent with the word at all times, including the first cycle after reset: it is 1 exactly when the word is below the floor.
- R6: The word saturates at all ones. A detector held at 0 drives it to 2^FREQ_W-1, where it stays and never rolls over to a low value.
- R7: Between consecutive clocks the word changes by at most one count, with no wrap in either direction.
- R8: The phase accumulator adds the word every clock. tank_drive is its most significant bit, so its frequency is word/2^PHASE_W of the clock.
- R9: Closed loop, with sense_quad a copy of sense_zero delayed by D clocks, the average word settles at 2^PHASE_W/(4·D), the point of a 90° lag. This holds for both capture options.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Asynchronous active-high reset |
| sense_zero | input | 1 | Asynchronous zero-crossing feedback |
| sense_quad | input | 1 | Asynchronous quadrature feedback |
| tank_drive | output | 1 | Square-wave drive to the resonator |
| freq_word | output | FREQ_W | Current frequency word |

## Verification
The assertions check on every cycle that the word moves by at most one count, that it never sits more than one count below the floor, that the low flag matches the word and forces an upward step, that saturation at all ones holds, that disagreeing dual-edge samples hold the word, and that the accumulator advances by the word. Only the bench's scenarios can show the longer behaviour. These are the exact slope under each detector pattern, the floor-1/floor alternation under a detector stuck at 1, the climb to saturation under a detector stuck at 0, and the settling of the closed loop on a resonator model at the frequency that gives a 90° lag.

// File: rtl/lcq_dpll_pkg.sv
package lcq_dpll_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b11
  } step_e;

  // Direction chosen from the detector output(s) and the low-frequency flag.
  // mis_a / mis_b: XOR of zero and quad for the rising / falling sample.
  function automatic step_e pick_step(input logic mis_a, input logic mis_b,
                                      input logic dual, input logic low);
    step_e s;
    if (low)                 s = STEP_UP;
    else if (!dual)          s = mis_a ? STEP_DN : STEP_UP;
    else if (mis_a && mis_b) s = STEP_DN;
    else if (!mis_a && !mis_b) s = STEP_UP;
    else                     s = STEP_HOLD;
    return s;
  endfunction

endpackage

// File: rtl/dpll_sense_sync.sv
module dpll_sense_sync #(
  parameter int SYNC_W    = 2,
  parameter bit DUAL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sense,
  output logic rise_s,
  output logic fall_s
);

  logic [SYNC_W-1:0] rise_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) rise_q <= '0;
    else     rise_q <= (rise_q << 1) | SYNC_W'(sense);
  end

  assign rise_s = rise_q[SYNC_W-1];

  generate
    if (DUAL_EDGE) begin : g_dual
      logic              fall_cap;
      logic [SYNC_W-1:0] fall_q;

      always_ff @(negedge clk or posedge rst) begin
        if (rst) fall_cap <= 1'b0;
        else     fall_cap <= sense;
      end

      always_ff @(posedge clk or posedge rst) begin
        if (rst) fall_q <= '0;
        else     fall_q <= (fall_q << 1) | SYNC_W'(fall_cap);
      end

      assign fall_s = fall_q[SYNC_W-1];
    end else begin : g_single
      assign fall_s = rise_s;
    end
  endgenerate

endmodule

// File: rtl/dpll_freq_loop.sv
module dpll_freq_loop
  import lcq_dpll_pkg::*;
#(
  parameter int FREQ_W    = 16,
  parameter int RANGE_W   = 2,
  parameter int FREQ_NOM  = 1800,
  parameter bit DUAL_EDGE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero_a,
  input  logic              zero_b,
  input  logic              quad_a,
  input  logic              quad_b,
  output logic [FREQ_W-1:0] freq_q,
  output logic              low_q
);

  localparam logic [FREQ_W-1:0] NOM   = FREQ_W'(FREQ_NOM);
  localparam int                OCT   = 2 ** RANGE_W;
  localparam logic [FREQ_W-1:0] FLOOR = NOM >> OCT;
  localparam logic [FREQ_W-1:0] TOP   = '1;

  // Saturating one-count move of the frequency word.
  function automatic logic [FREQ_W-1:0] apply_step(input logic [FREQ_W-1:0] w,
                                                    input step_e s);
    logic [FREQ_W-1:0] r;
    case (s)
      STEP_UP: r = (w == TOP) ? w : w + 1'b1;
      STEP_DN: r = (w == '0)  ? w : w - 1'b1;
      default: r = w;
    endcase
    return r;
  endfunction

  // Named internal events
  logic              mis_a, mis_b;
  step_e             step_w;
  logic [FREQ_W-1:0] next_w;

  assign mis_a  = zero_a ^ quad_a;
  assign mis_b  = zero_b ^ quad_b;
  assign step_w = pick_step(mis_a, mis_b, DUAL_EDGE, low_q);
  assign next_w = apply_step(freq_q, step_w);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      freq_q <= NOM;
      low_q  <= (NOM < FLOOR);
    end else begin
      freq_q <= next_w;
      low_q  <= (next_w < FLOOR);
    end
  end

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({1'b0, freq_q} == {1'b0, $past(freq_q)}) ||
             ({1'b0, freq_q} == {1'b0, $past(freq_q)} + 1'b1) ||
             ({1'b0, freq_q} + 1'b1 == {1'b0, $past(freq_q)}));

  // R4
  floor_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_q < FLOOR) |-> (freq_q == FLOOR - 1'b1));

  // R4
  low_force_chk: assert property (@(posedge clk) disable iff (rst)
    low_q |=> ({1'b0, freq_q} == {1'b0, $past(freq_q)} + 1'b1));

  // R5
  low_flag_chk: assert property (@(posedge clk) disable iff (rst)
    low_q == (freq_q < FLOOR));

  // R6
  sat_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_q == TOP) |=> (freq_q >= TOP - 1'b1));

  // R3
  ddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (DUAL_EDGE && !low_q && (mis_a != mis_b)) |=> $stable(freq_q));

endmodule

// File: rtl/dpll_nco.sv
module dpll_nco #(
  parameter int FREQ_W  = 16,
  parameter int PHASE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] word,
  output logic              drive
);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + PHASE_W'(word);
  end

  assign drive = phase_q[PHASE_W-1];

  // R8
  nco_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase_q == $past(phase_q) + PHASE_W'($past(word))));

endmodule

// File: rtl/lc_quad_dpll.sv
module lc_quad_dpll #(
  parameter int FREQ_W    = 16,
  parameter int PHASE_W   = 16,
  parameter int RANGE_W   = 2,
  parameter int SYNC_W    = 2,
  parameter bit DUAL_EDGE = 1'b0,
  parameter int FREQ_NOM  = 1800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sense_zero,
  input  logic              sense_quad,
  output logic              tank_drive,
  output logic [FREQ_W-1:0] freq_word
);

  logic zero_a, zero_b, quad_a, quad_b;
  logic low_flag;

  dpll_sense_sync #(.SYNC_W(SYNC_W), .DUAL_EDGE(DUAL_EDGE)) u_sync_zero (
    .clk(clk), .rst(rst), .sense(sense_zero), .rise_s(zero_a), .fall_s(zero_b));

  dpll_sense_sync #(.SYNC_W(SYNC_W), .DUAL_EDGE(DUAL_EDGE)) u_sync_quad (
    .clk(clk), .rst(rst), .sense(sense_quad), .rise_s(quad_a), .fall_s(quad_b));

  dpll_freq_loop #(
    .FREQ_W(FREQ_W), .RANGE_W(RANGE_W), .FREQ_NOM(FREQ_NOM), .DUAL_EDGE(DUAL_EDGE)
  ) u_loop (
    .clk(clk), .rst(rst),
    .zero_a(zero_a), .zero_b(zero_b), .quad_a(quad_a), .quad_b(quad_b),
    .freq_q(freq_word), .low_q(low_flag));

  dpll_nco #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_nco (
    .clk(clk), .rst(rst), .word(freq_word), .drive(tank_drive));

  // R1
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (freq_word == FREQ_W'(FREQ_NOM)) && !tank_drive);

endmodule

// File: tb/sim_lc_quad_dpll.sv
module sim_lc_quad_dpll;

  localparam int W     = 16;
  localparam int NOM   = 1800;
  localparam int FLOOR = NOM >> 4;              // RANGE_W=2 -> shift by 4
  localparam int DLY   = 8;                     // resonator model delay
  localparam int LOCK  = (1 << W) / (4 * DLY);  // 2048

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic mode = 1'b0;           // 0: vectors drive sense pins, 1: tank model
  logic vz = 1'b0, vq = 1'b0;
  logic [15:0] h0 = '0, h1 = '0;
  logic d0, d1;
  logic [W-1:0] w0, w1;
  logic z0, q0, z1, q1;

  assign z0 = mode ? h0[0]   : vz;
  assign q0 = mode ? h0[DLY] : vq;
  assign z1 = mode ? h1[0]   : vz;
  assign q1 = mode ? h1[DLY] : vq;

  lc_quad_dpll #(.DUAL_EDGE(1'b0)) u0 (
    .clk(clk), .rst(rst), .sense_zero(z0), .sense_quad(q0),
    .tank_drive(d0), .freq_word(w0));

  lc_quad_dpll #(.DUAL_EDGE(1'b1)) u1 (
    .clk(clk), .rst(rst), .sense_zero(z1), .sense_quad(q1),
    .tank_drive(d1), .freq_word(w1));

  always @(negedge clk) begin
    h0 <= {h0[14:0], d0};
    h1 <= {h1[14:0], d1};
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Step monitor (R7): count jumps larger than one count
  int jumps = 0;
  int prev0 = NOM, prev1 = NOM;
  always @(negedge clk) begin
    if (rst) begin
      prev0 <= NOM; prev1 <= NOM;
    end else begin
      if (int'(w0) - prev0 > 1 || prev0 - int'(w0) > 1) jumps++;
      if (int'(w1) - prev1 > 1 || prev1 - int'(w1) > 1) jumps++;
      prev0 <= int'(w0); prev1 <= int'(w1);
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(w0 == W'(NOM), "R1 word0", int'(w0), NOM);
    chk(w1 == W'(NOM), "R1 word1", int'(w1), NOM);
    chk(d0 == 1'b0,    "R1 drive0", int'(d0), 0);
    rst = 1'b0;
  endtask

  // {zero, quad, up}
  localparam logic [2:0] VEC [4] = '{3'b001, 3'b111, 3'b100, 3'b010};

  initial begin
    int a0, a1, b0, b1, mn0, mn1, sum0, sum1, rises;
    logic pd;
    do_reset();

    // R2 / R3: slope under each constant detector pattern
    for (int i = 0; i < 4; i++) begin
      vz = VEC[i][2]; vq = VEC[i][1];
      repeat (6) @(negedge clk);
      a0 = int'(w0); a1 = int'(w1);
      repeat (20) @(negedge clk);
      b0 = int'(w0); b1 = int'(w1);
      chk(b0 - a0 == (VEC[i][0] ? 20 : -20), "R2 slope", b0 - a0, VEC[i][0] ? 20 : -20);
      chk(b1 - a1 == (VEC[i][0] ? 20 : -20), "R3 slope", b1 - a1, VEC[i][0] ? 20 : -20);
    end

    // R4 / R5: detector stuck at 1 -> floor-1 / floor alternation
    do_reset();
    vz = 1'b1; vq = 1'b0;
    mn0 = NOM; mn1 = NOM;
    repeat (2000) begin
      @(negedge clk);
      if (int'(w0) < mn0) mn0 = int'(w0);
      if (int'(w1) < mn1) mn1 = int'(w1);
    end
    chk(mn0 == FLOOR - 1, "R4 min0", mn0, FLOOR - 1);
    chk(mn1 == FLOOR - 1, "R4 min1", mn1, FLOOR - 1);
    a0 = int'(w0);
    @(negedge clk);
    b0 = int'(w0);
    chk((a0 == FLOOR && b0 == FLOOR - 1) || (a0 == FLOOR - 1 && b0 == FLOOR),
        "R5 alternation", b0, a0 == FLOOR ? FLOOR - 1 : FLOOR);

    // R6: detector stuck at 0 -> saturate at all ones
    vz = 1'b0; vq = 1'b0;
    repeat (65600) @(negedge clk);
    chk(w0 == '1, "R6 sat0", int'(w0), (1 << W) - 1);
    chk(w1 == '1, "R6 sat1", int'(w1), (1 << W) - 1);
    repeat (10) @(negedge clk);
    chk(w0 == '1, "R6 hold0", int'(w0), (1 << W) - 1);
    chk(jumps == 0, "R7 jumps", jumps, 0);

    // R9 / R8: closed loop on the delayed-copy resonator model
    mode = 1'b1;
    do_reset();
    repeat (12000) @(negedge clk);
    sum0 = 0; sum1 = 0; rises = 0; pd = d0;
    repeat (640) begin
      @(negedge clk);
      sum0 += int'(w0); sum1 += int'(w1);
      if (d0 && !pd) rises++;
      pd = d0;
    end
    sum0 /= 640; sum1 /= 640;
    chk(sum0 > LOCK - 32 && sum0 < LOCK + 32, "R9 lock0", sum0, LOCK);
    chk(sum1 > LOCK - 32 && sum1 < LOCK + 32, "R9 lock1", sum1, LOCK);
    chk(rises >= 18 && rises <= 22, "R8 drive edges", rises, 20);
    chk(jumps == 0, "R7 jumps closed loop", jumps, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule